// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM Controller

This block connects a simple request port to an external synchronous SRAM. The SRAM moves four data words per access, on both edges of its clock. A request carries a burst address, a write flag and, for writes, a 144-bit payload made of four 36-bit words. The controller turns each accepted request into a one-cycle command on the SRAM bus: an active-low load strobe, a read/write select and the burst address. It places the four write words on the double-edge write path in the two cycles after the command. For reads, it collects the four words returned on the double-edge read path into one 144-bit result.

The core clock stands for the SRAM clock pair. Each core cycle carries two beats: a rise beat in its first half and a fall beat in its second half. Writes put their data on the bus one cycle after the command. Reads get their first word back one and a half cycles after the command. The SRAM adds the two low address bits to the burst address, counting upward from zero, and so picks the word for each beat. The controller accepts a new request at most every second cycle. This keeps bursts from colliding on either data path.

Top module: `burst4_sram_ctrl`

## Requirements
- R1: Once reset has been released and before any request arrives, mem_ld_n is high, rd_valid is low and req_ready is high.
- R2: A request is accepted in a cycle where req_valid and req_ready are both high. In the next cycle, and only in that cycle, mem_ld_n is low, mem_rw is 1 for a read or 0 for a write, and mem_addr equals req_addr.
- R3: req_ready is low in the cycle after an acceptance. A request presented while req_ready is low issues no command, so mem_ld_n stays high. Two command cycles are never adjacent.
- R4: In every cycle without a command, mem_ld_n is high.
- R5: For a write with command cycle t, the write beats are placed as follows. In cycle t+1, mem_d_rise carries req_wdata[35:0] and mem_d_fall carries req_wdata[71:36]. In cycle t+2, mem_d_rise carries req_wdata[107:72] and mem_d_fall carries req_wdata[143:108]. Beat k lands at word address {mem_addr, k[1:0]}.
- R6: For a read with command cycle t, the beats are sampled in this order: mem_q_fall in t+1, then mem_q_rise and mem_q_fall in t+2, then mem_q_rise in t+3. They become rd_data[35:0], [71:36], [107:72] and [143:108], in that order.
- R7: rd_valid is a one-cycle pulse in cycle t+4 of each read. Between pulses, rd_data holds its last value.
- R8: Reads issued every second cycle, whose beats share a cycle on the read path, each return their own data intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, standing for the SRAM clock pair |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | AW | Burst address |
| req_wdata | input | 4*DW | Four write words, word 0 in the low bits |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds a completed read |
| rd_data | output | 4*DW | Four read words, word 0 in the low bits |
| mem_ld_n | output | 1 | Active-low load strobe to the SRAM |
| mem_rw | output | 1 | 1 = read, 0 = write, valid while mem_ld_n is low |
| mem_addr | output | AW | Burst address to the SRAM |
| mem_d_rise | output | DW | Write beat for the first half-cycle |
| mem_d_fall | output | DW | Write beat for the second half-cycle |
| mem_q_rise | input | DW | Read beat for the first half-cycle |
| mem_q_fall | input | DW | Read beat for the second half-cycle |

## Verification
The bench builds the controller with DW=36 and AW=6, which gives a 256-word SRAM model. With so few addresses, random traffic keeps hitting the same bursts. This brings read-after-write ordering within reach, including a read issued while the preceding write's last beats are still landing. The bench also holds the request valid for several cycles in a row, which forces overlapping read bursts at the minimum two-cycle spacing.

// File: rtl/burst4_pkg.sv
package burst4_pkg;

    localparam int BEATS         = 4;
    localparam int BEATS_PER_CYC = 2;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    // Classify the command present on the SRAM bus in the current cycle.
    function automatic op_e bus_op(input logic ld_n, input logic rw);
        if (ld_n)
            return OP_NOP;
        return rw ? OP_READ : OP_WRITE;
    endfunction

endpackage

// File: rtl/b4_cmd_issue.sv
module b4_cmd_issue #(
    parameter int AW = 19,
    parameter int BW = 144
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [BW-1:0] req_wdata,
    output logic          req_ready,
    output logic          mem_ld_n,
    output logic          mem_rw,
    output logic [AW-1:0] mem_addr,
    output logic [BW-1:0] wr_payload
);

    logic busy;
    logic take;

    assign req_ready = ~busy;
    assign take      = req_valid & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            mem_ld_n   <= 1'b1;
            mem_rw     <= 1'b1;
            mem_addr   <= '0;
            wr_payload <= '0;
        end else begin
            busy     <= take;
            mem_ld_n <= ~take;
            if (take) begin
                mem_rw   <= ~req_write;
                mem_addr <= req_addr;
                if (req_write)
                    wr_payload <= req_wdata;
            end
        end
    end

    // R2
    accept_to_load_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!mem_ld_n && mem_addr == $past(req_addr)
                                      && mem_rw == !$past(req_write)));

    // R3
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    cmd_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_ld_n |=> mem_ld_n);

endmodule

// File: rtl/b4_wr_beats.sv
module b4_wr_beats
    import burst4_pkg::*;
#(
    parameter int DW = 36,
    localparam int BW = BEATS * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           bus_cmd,
    input  logic [BW-1:0] wr_payload,
    output logic [DW-1:0] mem_d_rise,
    output logic [DW-1:0] mem_d_fall
);

    logic [DW-1:0] lane [BEATS];
    logic          second_pair;

    for (genvar k = 0; k < BEATS; k++) begin : g_lane
        assign lane[k] = wr_payload[k*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            second_pair <= 1'b0;
            mem_d_rise  <= '0;
            mem_d_fall  <= '0;
        end else begin
            second_pair <= (bus_cmd == OP_WRITE);
            if (bus_cmd == OP_WRITE) begin
                mem_d_rise <= lane[0];
                mem_d_fall <= lane[1];
            end else if (second_pair) begin
                mem_d_rise <= lane[2];
                mem_d_fall <= lane[3];
            end else begin
                mem_d_rise <= '0;
                mem_d_fall <= '0;
            end
        end
    end

    // R3: a write pair must never start while the second pair of the previous write is out
    wr_pair_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == OP_WRITE) |=> (bus_cmd != OP_WRITE));

endmodule

// File: rtl/b4_rd_gather.sv
module b4_rd_gather
    import burst4_pkg::*;
#(
    parameter int DW = 36,
    localparam int BW = BEATS * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           bus_cmd,
    input  logic [DW-1:0] mem_q_rise,
    input  logic [DW-1:0] mem_q_fall,
    output logic          rd_valid,
    output logic [BW-1:0] rd_data
);

    // stage[0]: cycle t+1, stage[1]: t+2, stage[2]: t+3 of a read
    logic [2:0]    stage;
    logic [DW-1:0] part [3];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            for (int k = 0; k < 3; k++)
                part[k] <= '0;
        end else begin
            stage    <= {stage[1:0], bus_cmd == OP_READ};
            rd_valid <= stage[2];
            if (stage[0])
                part[0] <= mem_q_fall;
            if (stage[1]) begin
                part[1] <= mem_q_rise;
                part[2] <= mem_q_fall;
            end
            if (stage[2])
                rd_data <= {mem_q_rise, part[2], part[1], part[0]};
        end
    end

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> (rd_valid || $stable(rd_data)));

endmodule

// File: rtl/burst4_sram_ctrl.sv
module burst4_sram_ctrl
    import burst4_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 19,
    localparam int BW = BEATS * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [BW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [BW-1:0] rd_data,
    output logic          mem_ld_n,
    output logic          mem_rw,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_d_rise,
    output logic [DW-1:0] mem_d_fall,
    input  logic [DW-1:0] mem_q_rise,
    input  logic [DW-1:0] mem_q_fall
);

    logic [BW-1:0] wr_payload;
    op_e           bus_cmd;

    assign bus_cmd = bus_op(mem_ld_n, mem_rw);

    b4_cmd_issue #(.AW(AW), .BW(BW)) u_issue (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .mem_ld_n   (mem_ld_n),
        .mem_rw     (mem_rw),
        .mem_addr   (mem_addr),
        .wr_payload (wr_payload)
    );

    b4_wr_beats #(.DW(DW)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .bus_cmd    (bus_cmd),
        .wr_payload (wr_payload),
        .mem_d_rise (mem_d_rise),
        .mem_d_fall (mem_d_fall)
    );

    b4_rd_gather #(.DW(DW)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .bus_cmd    (bus_cmd),
        .mem_q_rise (mem_q_rise),
        .mem_q_fall (mem_q_fall),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    // R7
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_ld_n && mem_rw) |-> ##4 rd_valid);

    // R4
    nop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || !req_ready) |=> mem_ld_n);

endmodule

// File: tb/burst4_sram_ctrl_tb.sv
module burst4_sram_ctrl_tb;

    localparam int DW = 36;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int BW = NB * DW;
    localparam int WORDS = 1 << (AW + 2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rd_valid;
    logic [BW-1:0] rd_data;
    logic          mem_ld_n;
    logic          mem_rw;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_d_rise, mem_d_fall;
    logic [DW-1:0] mem_q_rise, mem_q_fall;

    always #4 clk = ~clk;

    burst4_sram_ctrl #(.DW(DW), .AW(AW)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_ld_n(mem_ld_n), .mem_rw(mem_rw), .mem_addr(mem_addr),
        .mem_d_rise(mem_d_rise), .mem_d_fall(mem_d_fall),
        .mem_q_rise(mem_q_rise), .mem_q_fall(mem_q_fall)
    );

    // ---------------- SRAM model: burst of four, words at {addr, 00..11} ----------------
    logic [DW-1:0] sram    [WORDS];
    logic [DW-1:0] ref_mem [WORDS];
    logic          wp1 = 0, wp2 = 0, rp1 = 0, rp2 = 0;
    logic [AW-1:0] wa1 = '0, wa2 = '0, ra1 = '0, ra2 = '0;

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            sram[i]    = '0;
            ref_mem[i] = '0;
        end
        mem_q_rise = '0;
        mem_q_fall = '0;
    end

    always @(posedge clk) begin
        if (rst) begin
            wp1 <= 0; wp2 <= 0; rp1 <= 0; rp2 <= 0;
        end else begin
            if (wp1) begin
                sram[{wa1, 2'b00}] = mem_d_rise;
                sram[{wa1, 2'b01}] = mem_d_fall;
            end
            if (wp2) begin
                sram[{wa2, 2'b10}] = mem_d_rise;
                sram[{wa2, 2'b11}] = mem_d_fall;
            end
            wp2 <= wp1; wa2 <= wa1;
            wp1 <= !mem_ld_n && !mem_rw; wa1 <= mem_addr;
            if (rp1) begin
                mem_q_rise <= sram[{ra1, 2'b01}];
                mem_q_fall <= sram[{ra1, 2'b10}];
            end
            if (rp2)
                mem_q_rise <= sram[{ra2, 2'b11}];
            if (!mem_ld_n && mem_rw)
                mem_q_fall <= sram[{mem_addr, 2'b00}];
            rp2 <= rp1; ra2 <= ra1;
            rp1 <= !mem_ld_n && mem_rw; ra1 <= mem_addr;
        end
    end

    // ---------------- scoreboard ----------------
    int errors = 0;
    int checks = 0;
    int cyc    = 0;

    int            cq_due[$];
    logic          cq_rd[$];
    logic [AW-1:0] cq_addr[$];
    int            wq_due[$];
    logic [BW-1:0] wq_data[$];
    int            rq_due[$];
    logic [BW-1:0] rq_data[$];
    logic [BW-1:0] last_rd = '0;

    task automatic chk(input bit ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] burst_of(input logic [AW-1:0] a);
        logic [BW-1:0] r;
        for (int k = 0; k < NB; k++)
            r[k*DW +: DW] = ref_mem[{a, 2'(k)}];
        return r;
    endfunction

    function automatic logic [BW-1:0] rand_burst();
        logic [BW-1:0] r;
        for (int k = 0; k < NB; k++)
            r[k*DW +: DW] = DW'({$urandom, $urandom});
        return r;
    endfunction

    task automatic observe();
        // R2 / R4 / R3: command bus
        if (cq_due.size() > 0 && cq_due[0] == cyc) begin
            chk(!mem_ld_n, "R2 load strobe", BW'(mem_ld_n), '0);
            chk(mem_rw == cq_rd[0], "R2 read/write select", BW'(mem_rw), BW'(cq_rd[0]));
            chk(mem_addr == cq_addr[0], "R2 address", BW'(mem_addr), BW'(cq_addr[0]));
            void'(cq_due.pop_front()); void'(cq_rd.pop_front()); void'(cq_addr.pop_front());
        end else begin
            chk(mem_ld_n, "R4 nop / R3 held request", BW'(mem_ld_n), BW'(1));
        end
        // R5: write beat placement
        if (wq_due.size() > 0 && wq_due[0] == cyc) begin
            chk(mem_d_rise == wq_data[0][0 +: DW], "R5 beat0 rise",
                BW'(mem_d_rise), BW'(wq_data[0][0 +: DW]));
            chk(mem_d_fall == wq_data[0][DW +: DW], "R5 beat1 fall",
                BW'(mem_d_fall), BW'(wq_data[0][DW +: DW]));
        end else if (wq_due.size() > 0 && wq_due[0] + 1 == cyc) begin
            chk(mem_d_rise == wq_data[0][2*DW +: DW], "R5 beat2 rise",
                BW'(mem_d_rise), BW'(wq_data[0][2*DW +: DW]));
            chk(mem_d_fall == wq_data[0][3*DW +: DW], "R5 beat3 fall",
                BW'(mem_d_fall), BW'(wq_data[0][3*DW +: DW]));
            void'(wq_due.pop_front()); void'(wq_data.pop_front());
        end
        // R6 / R7 / R8: read return
        if (rq_due.size() > 0 && rq_due[0] == cyc) begin
            chk(rd_valid, "R7 read pulse", BW'(rd_valid), BW'(1));
            chk(rd_data == rq_data[0], "R6 R8 read burst", rd_data, rq_data[0]);
            last_rd = rq_data[0];
            void'(rq_due.pop_front()); void'(rq_data.pop_front());
        end else begin
            chk(!rd_valid, "R7 no stray pulse", BW'(rd_valid), '0);
            chk(rd_data == last_rd, "R7 data hold", rd_data, last_rd);
        end
    endtask

    task automatic step(input logic v, input logic w, input logic [AW-1:0] a,
                        input logic [BW-1:0] d);
        @(negedge clk);
        cyc++;
        observe();
        req_valid = v;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        #1;
        if (v && req_ready) begin
            cq_due.push_back(cyc + 1); cq_rd.push_back(!w); cq_addr.push_back(a);
            if (w) begin
                for (int k = 0; k < NB; k++)
                    ref_mem[{a, 2'(k)}] = d[k*DW +: DW];
                wq_due.push_back(cyc + 2); wq_data.push_back(d);
            end else begin
                rq_due.push_back(cyc + 5); rq_data.push_back(burst_of(a));
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            step(1'b0, 1'b0, '0, '0);
    endtask

    initial begin
        logic [BW-1:0] pat;
        void'($urandom(32'd1729));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        chk(mem_ld_n, "R1 strobe high", BW'(mem_ld_n), BW'(1));
        chk(!rd_valid, "R1 no read pulse", BW'(rd_valid), '0);
        chk(req_ready, "R1 ready", BW'(req_ready), BW'(1));

        // directed: one write, then its beats in the SRAM at ascending low bits (R5)
        pat = rand_burst();
        step(1'b1, 1'b1, 6'd5, pat);
        idle(5);
        for (int k = 0; k < NB; k++)
            chk(sram[{6'd5, 2'(k)}] == pat[k*DW +: DW], "R5 word order",
                BW'(sram[{6'd5, 2'(k)}]), BW'(pat[k*DW +: DW]));
        step(1'b1, 1'b0, 6'd5, '0);            // R6 read back
        idle(6);

        // directed: valid held high -> every other cycle accepted, overlapping reads (R3, R8)
        for (int i = 0; i < 4; i++)
            step(1'b1, 1'b1, 6'(i + 10), rand_burst());
        for (int i = 0; i < 8; i++)
            step(1'b1, 1'b0, 6'(10 + (i % 4)), '0);
        // write then read the same burst at minimum spacing
        pat = rand_burst();
        step(1'b1, 1'b1, 6'd20, pat);
        step(1'b1, 1'b0, 6'd20, '0);
        step(1'b1, 1'b0, 6'd20, '0);
        idle(8);

        // random traffic
        for (int i = 0; i < 1500; i++)
            step(($urandom % 4) != 0, $urandom % 2, 6'($urandom), rand_burst());
        idle(10);
        chk(rq_due.size() == 0 && wq_due.size() == 0 && cq_due.size() == 0,
            "R2 R6 all bursts completed", BW'(rq_due.size() + wq_due.size()), '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule